// File: doc/BRIEF.md
# Wrong-Path Aware Victim Selector

This block keeps the replacement state of a set-associative cache. For every way of every set it holds a valid bit, a recency age and one origin bit that marks whether the line was brought in by a reference later found to lie on a mispredicted branch path. The data and tag arrays live elsewhere. This block only sees the events that change replacement state and answers which way should be replaced next.

Four ports drive it. The fill port installs a line and records its origin. The access port reports a hit, which refreshes recency; a hit from a correct-path reference also removes the wrong-path mark. The invalidate port drops a line. The victim query port takes a set index and returns a way combinationally. The victim is the lowest invalid way if the set has one. Otherwise it is the oldest wrong-path line. When the full set holds only correct-path lines, it is the oldest line of the set.

Top module: `wpv_victim_sel`

## Requirements
- R1: A fill makes the way valid and sets its origin bit to `fill_wrong_path_i` (1 = wrong path), replacing any earlier mark.
- R2: If the queried set has any invalid way, `victim_way_o` names an invalid way.
- R3: If all ways of the queried set are valid and at least one is marked wrong-path, `victim_way_o` is the least recently used of the marked ways.
- R4: An access with `acc_correct_i`=1 to a valid way clears that way's wrong-path mark.
- R5: If all ways are valid and none is marked, `victim_way_o` is the least recently used way of the set.
- R6: A fill, or an access to a valid way, makes that way the most recent of its set and keeps the relative order of the other ways.
- R7: An access with `acc_correct_i`=0 to a valid way updates recency but leaves the origin bit unchanged.
- R8: Among several invalid ways, the lowest-numbered one is chosen.
- R9: An invalidate clears the valid bit and the wrong-path mark of the way.
- R10: After reset every way of every set is invalid, so the victim of every set is way 0.
- R11: An access to an invalid way has no effect: the way stays invalid.
- R12: Events in one cycle on the same set apply in the order access, fill, invalidate. The victim query reflects every event from earlier cycles and none from the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Fill event |
| fill_set_i | input | SET_W | Fill set index |
| fill_way_i | input | WAY_W | Fill way |
| fill_wrong_path_i | input | 1 | Filled line came from a wrong-path reference |
| acc_valid_i | input | 1 | Hit event |
| acc_set_i | input | SET_W | Hit set index |
| acc_way_i | input | WAY_W | Hit way |
| acc_correct_i | input | 1 | Hit came from a correct-path reference |
| inval_valid_i | input | 1 | Invalidate event |
| inval_set_i | input | SET_W | Invalidate set index |
| inval_way_i | input | WAY_W | Invalidate way |
| query_set_i | input | SET_W | Set whose victim is requested |
| victim_way_o | output | WAY_W | Chosen victim way for `query_set_i` |

## Verification
A fill, access or invalidate takes effect at the next rising edge, so the victim for that set is first visible one cycle after the event. The victim output depends combinationally on `query_set_i` and on the stored state. The bench therefore drives events and the query on the falling edge, settles briefly, compares the victim against a behavioural model that still holds the pre-edge state, and only then lets the model absorb the events at the rising edge. Directed sequences check hand-computed victims one cycle after each event. Random traffic concentrated on a few sets produces same-cycle collisions for the ordering rule.

// File: rtl/wpv_pkg.sv
package wpv_pkg;
  typedef enum logic [1:0] {
    PICK_INVALID = 2'd0,
    PICK_WRONG   = 2'd1,
    PICK_LRU     = 2'd2
  } pick_e;
endpackage

// File: rtl/wpv_set_state.sv
module wpv_set_state #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            acc_en_i,
  input  logic [WAY_W-1:0]                acc_way_i,
  input  logic                            acc_correct_i,
  input  logic                            fill_en_i,
  input  logic [WAY_W-1:0]                fill_way_i,
  input  logic                            fill_wp_i,
  input  logic                            inv_en_i,
  input  logic [WAY_W-1:0]                inv_way_i,
  output logic [NUM_WAYS-1:0]             valid_o,
  output logic [NUM_WAYS-1:0]             wp_o,
  output logic [NUM_WAYS-1:0][WAY_W-1:0]  age_o
);
  logic [NUM_WAYS-1:0]            valid_q, valid_d;
  logic [NUM_WAYS-1:0]            wp_q, wp_d;
  logic [NUM_WAYS-1:0][WAY_W-1:0] age_q, age_d;

  // Promote one way to age 0; ways younger than it age by one.
  function automatic logic [NUM_WAYS-1:0][WAY_W-1:0] touch(
    input logic [NUM_WAYS-1:0][WAY_W-1:0] cur,
    input logic [WAY_W-1:0]               way
  );
    logic [NUM_WAYS-1:0][WAY_W-1:0] nxt;
    logic [WAY_W-1:0]               ref_age;
    nxt     = cur;
    ref_age = cur[way];
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (cur[i] < ref_age) nxt[i] = cur[i] + WAY_W'(1);
    end
    nxt[way] = '0;
    return nxt;
  endfunction

  always_comb begin
    valid_d = valid_q;
    wp_d    = wp_q;
    age_d   = age_q;
    if (acc_en_i && valid_d[acc_way_i]) begin
      age_d = touch(age_d, acc_way_i);
      if (acc_correct_i) wp_d[acc_way_i] = 1'b0;
    end
    if (fill_en_i) begin
      valid_d[fill_way_i] = 1'b1;
      wp_d[fill_way_i]    = fill_wp_i;
      age_d               = touch(age_d, fill_way_i);
    end
    if (inv_en_i) begin
      valid_d[inv_way_i] = 1'b0;
      wp_d[inv_way_i]    = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      wp_q    <= '0;
      for (int i = 0; i < NUM_WAYS; i++) age_q[i] <= WAY_W'(i);
    end else begin
      valid_q <= valid_d;
      wp_q    <= wp_d;
      age_q   <= age_d;
    end
  end

  assign valid_o = valid_q;
  assign wp_o    = wp_q;
  assign age_o   = age_q;
endmodule

// File: rtl/wpv_victim_pick.sv
module wpv_victim_pick
  import wpv_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0]            valid_i,
  input  logic [NUM_WAYS-1:0]            wp_i,
  input  logic [NUM_WAYS-1:0][WAY_W-1:0] age_i,
  output logic [WAY_W-1:0]               victim_o
);
  logic             inv_found, wp_found;
  logic [WAY_W-1:0] inv_way, wp_way, wp_age, lru_way;
  pick_e            pick;

  always_comb begin
    inv_found = 1'b0;
    inv_way   = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        inv_found = 1'b1;
        inv_way   = WAY_W'(i);
      end
    end
    wp_found = 1'b0;
    wp_way   = '0;
    wp_age   = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (wp_i[i] && (!wp_found || age_i[i] > wp_age)) begin
        wp_found = 1'b1;
        wp_way   = WAY_W'(i);
        wp_age   = age_i[i];
      end
    end
    lru_way = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (age_i[i] == WAY_W'(NUM_WAYS - 1)) lru_way = WAY_W'(i);
    end
    if (inv_found)     pick = PICK_INVALID;
    else if (wp_found) pick = PICK_WRONG;
    else               pick = PICK_LRU;
    case (pick)
      PICK_INVALID: victim_o = inv_way;
      PICK_WRONG:   victim_o = wp_way;
      default:      victim_o = lru_way;
    endcase
  end
endmodule

// File: rtl/wpv_victim_sel.sv
module wpv_victim_sel #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_valid_i,
  input  logic [SET_W-1:0] fill_set_i,
  input  logic [WAY_W-1:0] fill_way_i,
  input  logic             fill_wrong_path_i,
  input  logic             acc_valid_i,
  input  logic [SET_W-1:0] acc_set_i,
  input  logic [WAY_W-1:0] acc_way_i,
  input  logic             acc_correct_i,
  input  logic             inval_valid_i,
  input  logic [SET_W-1:0] inval_set_i,
  input  logic [WAY_W-1:0] inval_way_i,
  input  logic [SET_W-1:0] query_set_i,
  output logic [WAY_W-1:0] victim_way_o
);
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]            st_valid;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0]            st_wp;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] st_age;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    wpv_set_state #(.NUM_WAYS(NUM_WAYS)) u_state (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .acc_en_i      (acc_valid_i && (acc_set_i == SET_W'(s))),
      .acc_way_i     (acc_way_i),
      .acc_correct_i (acc_correct_i),
      .fill_en_i     (fill_valid_i && (fill_set_i == SET_W'(s))),
      .fill_way_i    (fill_way_i),
      .fill_wp_i     (fill_wrong_path_i),
      .inv_en_i      (inval_valid_i && (inval_set_i == SET_W'(s))),
      .inv_way_i     (inval_way_i),
      .valid_o       (st_valid[s]),
      .wp_o          (st_wp[s]),
      .age_o         (st_age[s])
    );
  end

  logic [NUM_WAYS-1:0]            q_valid;
  logic [NUM_WAYS-1:0]            q_wp;
  logic [NUM_WAYS-1:0][WAY_W-1:0] q_age;

  assign q_valid = st_valid[query_set_i];
  assign q_wp    = st_wp[query_set_i];
  assign q_age   = st_age[query_set_i];

  wpv_victim_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .valid_i  (q_valid),
    .wp_i     (q_wp),
    .age_i    (q_age),
    .victim_o (victim_way_o)
  );
endmodule

// File: rtl/wpv_victim_sel_chk.sv
module wpv_victim_sel_chk #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
  localparam int WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input logic                                         clk_i,
  input logic                                         rst_ni,
  input logic                                         fill_valid_i,
  input logic [SET_W-1:0]                             fill_set_i,
  input logic [WAY_W-1:0]                             fill_way_i,
  input logic                                         fill_wrong_path_i,
  input logic                                         acc_valid_i,
  input logic [SET_W-1:0]                             acc_set_i,
  input logic [WAY_W-1:0]                             acc_way_i,
  input logic                                         acc_correct_i,
  input logic                                         inval_valid_i,
  input logic [SET_W-1:0]                             inval_set_i,
  input logic [WAY_W-1:0]                             inval_way_i,
  input logic [WAY_W-1:0]                             victim_way_o,
  input logic [NUM_WAYS-1:0]                          q_valid,
  input logic [NUM_WAYS-1:0]                          q_wp,
  input logic [NUM_WAYS-1:0][WAY_W-1:0]               q_age,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0]            st_valid,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0]            st_wp,
  input logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] st_age
);
  logic [NUM_WAYS-1:0] below_mask;
  assign below_mask = (NUM_WAYS'(1) << victim_way_o) - NUM_WAYS'(1);

  logic acc_fill_hit, acc_inv_hit;
  assign acc_fill_hit = fill_valid_i && fill_set_i == acc_set_i && fill_way_i == acc_way_i;
  assign acc_inv_hit  = inval_valid_i && inval_set_i == acc_set_i && inval_way_i == acc_way_i;

  p_fill_marks_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i && !(inval_valid_i && inval_set_i == fill_set_i && inval_way_i == fill_way_i)
    |=> st_valid[$past(fill_set_i)][$past(fill_way_i)] &&
        st_wp[$past(fill_set_i)][$past(fill_way_i)] == $past(fill_wrong_path_i));

  p_invalid_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&q_valid) |-> !q_valid[victim_way_o]);

  p_oldest_wrong_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&q_valid) && (|q_wp) |-> q_wp[victim_way_o]);

  p_correct_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_correct_i && st_valid[acc_set_i][acc_way_i] && !acc_fill_hit
    |=> !st_wp[$past(acc_set_i)][$past(acc_way_i)]);

  p_plain_lru_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&q_valid) && !(|q_wp) |-> q_age[victim_way_o] == WAY_W'(NUM_WAYS - 1));

  p_fill_mru_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> st_age[$past(fill_set_i)][$past(fill_way_i)] == '0);

  p_wrong_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !acc_correct_i && st_valid[acc_set_i][acc_way_i] && !acc_fill_hit && !acc_inv_hit
    |=> st_wp[$past(acc_set_i)][$past(acc_way_i)] == $past(st_wp[acc_set_i][acc_way_i]));

  p_lowest_invalid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&q_valid) |-> ((~q_valid) & below_mask) == '0);

  p_inval_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_valid_i |=> !st_valid[$past(inval_set_i)][$past(inval_way_i)] &&
                      !st_wp[$past(inval_set_i)][$past(inval_way_i)]);
endmodule

bind wpv_victim_sel wpv_victim_sel_chk #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .fill_valid_i      (fill_valid_i),
  .fill_set_i        (fill_set_i),
  .fill_way_i        (fill_way_i),
  .fill_wrong_path_i (fill_wrong_path_i),
  .acc_valid_i       (acc_valid_i),
  .acc_set_i         (acc_set_i),
  .acc_way_i         (acc_way_i),
  .acc_correct_i     (acc_correct_i),
  .inval_valid_i     (inval_valid_i),
  .inval_set_i       (inval_set_i),
  .inval_way_i       (inval_way_i),
  .victim_way_o      (victim_way_o),
  .q_valid           (q_valid),
  .q_wp              (q_wp),
  .q_age             (q_age),
  .st_valid          (st_valid),
  .st_wp             (st_wp),
  .st_age            (st_age)
);

// File: tb/tb_wpv_victim_sel.sv
module tb_wpv_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NW = 4;
  localparam int SW = $clog2(NS);
  localparam int WW = $clog2(NW);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fill_valid_i = 0, fill_wrong_path_i = 0;
  logic [SW-1:0] fill_set_i = '0, acc_set_i = '0, inval_set_i = '0, query_set_i = '0;
  logic [WW-1:0] fill_way_i = '0, acc_way_i = '0, inval_way_i = '0;
  logic acc_valid_i = 0, acc_correct_i = 0, inval_valid_i = 0;
  logic [WW-1:0] victim_way_o;

  int checks = 0;
  int errors = 0;

  bit mv [NS][NW];
  bit mw [NS][NW];
  int rec [NS][$];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  wpv_victim_sel #(.NUM_SETS(NS), .NUM_WAYS(NW)) dut (.*);

  task automatic model_touch(input int s, input int w);
    for (int i = 0; i < rec[s].size(); i++) begin
      if (rec[s][i] == w) begin
        rec[s].delete(i);
        break;
      end
    end
    rec[s].push_front(w);
  endtask

  function automatic int model_victim(input int s, output string why);
    for (int w = 0; w < NW; w++) if (!mv[s][w]) begin why = "R2 R8"; return w; end
    for (int i = rec[s].size() - 1; i >= 0; i--)
      if (mw[s][rec[s][i]]) begin why = "R3"; return rec[s][i]; end
    why = "R5";
    return rec[s][rec[s].size() - 1];
  endfunction

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: victim actual %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, compare pre-edge victim, then advance model (R12 order).
  task automatic step(input bit fv, input int fs, input int fw, input bit fwp,
                      input bit av, input int as, input int aw, input bit ac,
                      input bit iv, input int is, input int iw, input int qs);
    string why;
    int exp;
    @(negedge clk_i);
    fill_valid_i = fv;  fill_set_i = SW'(fs);  fill_way_i = WW'(fw);  fill_wrong_path_i = fwp;
    acc_valid_i = av;   acc_set_i = SW'(as);   acc_way_i = WW'(aw);   acc_correct_i = ac;
    inval_valid_i = iv; inval_set_i = SW'(is); inval_way_i = WW'(iw);
    query_set_i = SW'(qs);
    #1;
    exp = model_victim(qs, why);
    check(int'(victim_way_o), exp, why);
    @(posedge clk_i);
    if (av && mv[as][aw]) begin
      model_touch(as, aw);
      if (ac) mw[as][aw] = 1'b0;
    end
    if (fv) begin
      mv[fs][fw] = 1'b1;
      mw[fs][fw] = fwp;
      model_touch(fs, fw);
    end
    if (iv) begin
      mv[is][iw] = 1'b0;
      mw[is][iw] = 1'b0;
    end
  endtask

  task automatic fill(input int s, input int w, input bit wp);
    step(1, s, w, wp, 0, 0, 0, 0, 0, 0, 0, s);
  endtask
  task automatic hit(input int s, input int w, input bit cp);
    step(0, 0, 0, 0, 1, s, w, cp, 0, 0, 0, s);
  endtask
  task automatic inval(input int s, input int w);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, s, w, s);
  endtask
  task automatic peek(input int s, input int exp, input string tag);
    @(negedge clk_i);
    fill_valid_i = 0; acc_valid_i = 0; inval_valid_i = 0;
    query_set_i = SW'(s);
    #1;
    check(int'(victim_way_o), exp, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < NW; w++) begin
        mv[s][w] = 0; mw[s][w] = 0; rec[s].push_back(w);
      end
    end
    repeat (3) @(negedge clk_i);
    peek(0, 0, "R10");
    rst_ni = 1'b1;
    peek(0, 0, "R10");
    peek(5, 0, "R10");

    // Set 1: correct-path only
    for (int w = 0; w < NW; w++) fill(1, w, 0);
    peek(1, 0, "R5");
    hit(1, 0, 1);
    peek(1, 1, "R6");

    // Set 2: mixed origins
    fill(2, 0, 1); fill(2, 1, 0); fill(2, 2, 1); fill(2, 3, 0);
    peek(2, 0, "R1 R3");
    hit(2, 0, 0);
    peek(2, 2, "R7");
    hit(2, 2, 1);
    peek(2, 0, "R4");
    hit(2, 0, 1);
    peek(2, 1, "r4_r5");
    inval(2, 3);
    peek(2, 3, "R9");
    inval(2, 1);
    peek(2, 1, "R8");
    hit(2, 3, 1);
    peek(2, 1, "R11");
    fill(2, 1, 0);
    peek(2, 3, "R11");

    // Set 6: same-cycle ordering
    for (int w = 0; w < NW; w++) fill(6, w, 0);
    step(1, 6, 1, 1, 0, 0, 0, 0, 1, 6, 1, 6);
    peek(6, 1, "R12");
    fill(6, 1, 0);
    peek(6, 0, "R12");
    step(1, 6, 2, 1, 1, 6, 2, 1, 0, 0, 0, 6);
    peek(6, 2, "R12");

    // Random traffic over few sets to force collisions
    for (int n = 0; n < 4000; n++) begin
      step($urandom % 2, $urandom % 4, $urandom % NW, $urandom % 2,
           $urandom % 2, $urandom % 4, $urandom % NW, $urandom % 2,
           ($urandom % 5) == 0, $urandom % 4, $urandom % NW, $urandom % 4);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule